// File: doc/BRIEF.md
# Segmented-Carry SHA-256 Compression Core

This block performs the compression step of SHA-256 for one 512-bit message block, one round per clock. It holds the eight 32-bit working words, consumes one externally scheduled message word per round, mixes in a built-in round constant, and after the last round folds the working words back into the chaining value. The result is a 256-bit digest that stays on the output until the next block is started.

Every modular addition in the core, including the eight feed-forward additions, is done by one parameterised adder. That adder cuts the 32-bit word into independent slices of `SEG_W` bits. No carry crosses a slice boundary: a slice takes no carry in, and its carry out is lost. This shortens the longest carry path through the new-A update at the price of a digest that differs from the standard one. With `SEG_W` = 32 there is a single slice and the core computes standard SHA-256.

The block does not pad messages and does not schedule message words. A caller chains blocks by starting the core with the chaining input selected and the previous digest on that input.

Top module: `sha_apx_core`

## Requirements
- R1: While reset is high and right after it is released, `done` and `word_req` are 0 and `digest` is all zeros.
- R2: An accepted `start` is followed by exactly 64 consecutive cycles with `word_req` high. The word on `word_in` at the clock edge ending the n-th such cycle is used as the message word of round n-1.
- R3: `done` rises exactly two cycles after the last cycle with `word_req` high. The first cycle is the last round's result and the second is the feed-forward. Counted from the edge that accepts `start`, `done` is first seen high in the 66th cycle. `done` is never high together with `word_req`.
- R4: With `SEG_W` = 32 and the built-in initial value selected, the padded block of the three-byte message "abc" (word 0 = 0x61626380, word 15 = 0x00000018, all other words zero) gives digest 0xba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad.
- R5: For `SEG_W` = 4, the digest equals a model that uses segmented addition for every sum. The sums are formed in this order: T1 = (((H + Σ1(E)) + Ch(E,F,G)) + Kt) + Wt, T2 = Σ0(A) + Maj(A,B,C), new A = T1 + T2, new E = D + T1. Output word i = chaining word i + working word i. Σ0 rotates right by 2, 13 and 22, and Σ1 by 6, 11 and 25.
- R6: When `use_iv` is 1 at the accepted start, the chaining value is the eight standard initial hash words. When it is 0, it is `chain_in`, with word 0 (A) in bits 255:224 down to word 7 (H) in bits 31:0. The digest uses the same word order.
- R7: A `start` that arrives while a block is in progress (rounds or feed-forward) is ignored. The run keeps its 64 request cycles, its timing and its digest.
- R8: With `SEG_W` = 1, every sum is the bitwise XOR of its operands, so the digest equals the R5 model with every addition replaced by XOR.
- R9: While `done` is high and no `start` arrives, `digest` and `done` stay unchanged. A `start` accepted in that state drops `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; accepted only when idle or finished |
| use_iv | input | 1 | 1: chain from built-in initial value; 0: from `chain_in` |
| chain_in | input | 256 | Incoming chaining value, word 0 in the top bits |
| word_in | input | 32 | Message word for the round currently requested |
| word_req | output | 1 | High during each of the 64 round cycles |
| done | output | 1 | High once the digest is valid, until the next start |
| digest | output | 256 | Feed-forward result, word 0 in the top bits |

## Verification
The core is driven three ways in parallel, at slice widths 32, 4 and 1, with the same message words. The known "abc" block separates a correct exact datapath from wrong constants, rotations or word order. The same block at width 4 shows whether carries are dropped at exactly the slice boundaries and whether the sums are formed in the required order, which a plain adder or another grouping would get wrong. At width 1 the XOR-only result exposes any carry that leaks at all. A second, dense block chained from an arbitrary external value tests the `chain_in` path. A start pulse injected mid-run and a long wait after completion test the busy guard and the hold behaviour.

// File: rtl/sha_apx_pkg.sv
package sha_apx_pkg;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] d;
        logic [31:0] e;
        logic [31:0] f;
        logic [31:0] g;
        logic [31:0] h;
    } work_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2,
        ST_DONE = 2'd3
    } core_st_t;

    localparam logic [255:0] INIT_CHAIN = {
        32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
        32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
    };

    function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] big_sig0(input logic [31:0] x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic logic [31:0] big_sig1(input logic [31:0] x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic logic [31:0] choose(input logic [31:0] x, input logic [31:0] y,
                                           input logic [31:0] z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic logic [31:0] majority(input logic [31:0] x, input logic [31:0] y,
                                             input logic [31:0] z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic logic [31:0] round_const(input logic [5:0] idx);
        logic [31:0] k;
        case (idx)
            6'd0:  k = 32'h428a2f98;  6'd1:  k = 32'h71374491;
            6'd2:  k = 32'hb5c0fbcf;  6'd3:  k = 32'he9b5dba5;
            6'd4:  k = 32'h3956c25b;  6'd5:  k = 32'h59f111f1;
            6'd6:  k = 32'h923f82a4;  6'd7:  k = 32'hab1c5ed5;
            6'd8:  k = 32'hd807aa98;  6'd9:  k = 32'h12835b01;
            6'd10: k = 32'h243185be;  6'd11: k = 32'h550c7dc3;
            6'd12: k = 32'h72be5d74;  6'd13: k = 32'h80deb1fe;
            6'd14: k = 32'h9bdc06a7;  6'd15: k = 32'hc19bf174;
            6'd16: k = 32'he49b69c1;  6'd17: k = 32'hefbe4786;
            6'd18: k = 32'h0fc19dc6;  6'd19: k = 32'h240ca1cc;
            6'd20: k = 32'h2de92c6f;  6'd21: k = 32'h4a7484aa;
            6'd22: k = 32'h5cb0a9dc;  6'd23: k = 32'h76f988da;
            6'd24: k = 32'h983e5152;  6'd25: k = 32'ha831c66d;
            6'd26: k = 32'hb00327c8;  6'd27: k = 32'hbf597fc7;
            6'd28: k = 32'hc6e00bf3;  6'd29: k = 32'hd5a79147;
            6'd30: k = 32'h06ca6351;  6'd31: k = 32'h14292967;
            6'd32: k = 32'h27b70a85;  6'd33: k = 32'h2e1b2138;
            6'd34: k = 32'h4d2c6dfc;  6'd35: k = 32'h53380d13;
            6'd36: k = 32'h650a7354;  6'd37: k = 32'h766a0abb;
            6'd38: k = 32'h81c2c92e;  6'd39: k = 32'h92722c85;
            6'd40: k = 32'ha2bfe8a1;  6'd41: k = 32'ha81a664b;
            6'd42: k = 32'hc24b8b70;  6'd43: k = 32'hc76c51a3;
            6'd44: k = 32'hd192e819;  6'd45: k = 32'hd6990624;
            6'd46: k = 32'hf40e3585;  6'd47: k = 32'h106aa070;
            6'd48: k = 32'h19a4c116;  6'd49: k = 32'h1e376c08;
            6'd50: k = 32'h2748774c;  6'd51: k = 32'h34b0bcb5;
            6'd52: k = 32'h391c0cb3;  6'd53: k = 32'h4ed8aa4a;
            6'd54: k = 32'h5b9cca4f;  6'd55: k = 32'h682e6ff3;
            6'd56: k = 32'h748f82ee;  6'd57: k = 32'h78a5636f;
            6'd58: k = 32'h84c87814;  6'd59: k = 32'h8cc70208;
            6'd60: k = 32'h90befffa;  6'd61: k = 32'ha4506ceb;
            6'd62: k = 32'hbef9a3f7;  default: k = 32'hc67178f2;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/sha_apx_segadd.sv
// Sliced adder: each SEG-bit slice adds on its own; carries never cross slices.
module sha_apx_segadd #(
    parameter int WIDTH = 32,
    parameter int SEG   = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] s
);
    localparam int NSEG = WIDTH / SEG;

    for (genvar i = 0; i < NSEG; i++) begin : g_slice
        assign s[i*SEG +: SEG] = x[i*SEG +: SEG] + y[i*SEG +: SEG];
    end
endmodule

// File: rtl/sha_apx_round.sv
// One compression round, every sum through the sliced adder.
module sha_apx_round
    import sha_apx_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  work_t       cur,
    input  logic [31:0] kt,
    input  logic [31:0] wt,
    output work_t       nxt
);
    logic [31:0] s1_v, ch_v, s0_v, mj_v;
    logic [31:0] p1, p2, p3, t1, t2, new_a, new_e;

    assign s1_v = big_sig1(cur.e);
    assign ch_v = choose(cur.e, cur.f, cur.g);
    assign s0_v = big_sig0(cur.a);
    assign mj_v = majority(cur.a, cur.b, cur.c);

    sha_apx_segadd #(.WIDTH(32), .SEG(SEG_W)) u_p1 (.x(cur.h), .y(s1_v), .s(p1));
    sha_apx_segadd #(.WIDTH(32), .SEG(SEG_W)) u_p2 (.x(p1),    .y(ch_v), .s(p2));
    sha_apx_segadd #(.WIDTH(32), .SEG(SEG_W)) u_p3 (.x(p2),    .y(kt),   .s(p3));
    sha_apx_segadd #(.WIDTH(32), .SEG(SEG_W)) u_t1 (.x(p3),    .y(wt),   .s(t1));
    sha_apx_segadd #(.WIDTH(32), .SEG(SEG_W)) u_t2 (.x(s0_v),  .y(mj_v), .s(t2));
    sha_apx_segadd #(.WIDTH(32), .SEG(SEG_W)) u_na (.x(t1),    .y(t2),   .s(new_a));
    sha_apx_segadd #(.WIDTH(32), .SEG(SEG_W)) u_ne (.x(cur.d), .y(t1),   .s(new_e));

    always_comb begin
        nxt.a = new_a;
        nxt.b = cur.a;
        nxt.c = cur.b;
        nxt.d = cur.c;
        nxt.e = new_e;
        nxt.f = cur.e;
        nxt.g = cur.f;
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sha_apx_core.sv
module sha_apx_core
    import sha_apx_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int ROUNDS = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         use_iv,
    input  logic [255:0] chain_in,
    input  logic [31:0]  word_in,
    output logic         word_req,
    output logic         done,
    output logic [255:0] digest
);
    localparam int RW     = $clog2(ROUNDS);
    localparam int NWORDS = 8;

    core_st_t       st;
    logic [RW-1:0]  rnd;
    work_t          work_q, work_nx;
    logic [255:0]   chain_q, ff_sum, work_vec, load_val;
    logic [255:0]   digest_q;
    logic           accept;
    logic [31:0]    kt;

    assign accept   = start && (st == ST_IDLE || st == ST_DONE);
    assign load_val = use_iv ? INIT_CHAIN : chain_in;
    assign kt       = round_const(6'(rnd));
    assign work_vec = work_q;

    sha_apx_round #(.SEG_W(SEG_W)) u_round (
        .cur (work_q),
        .kt  (kt),
        .wt  (word_in),
        .nxt (work_nx)
    );

    for (genvar i = 0; i < NWORDS; i++) begin : g_ff
        sha_apx_segadd #(.WIDTH(32), .SEG(SEG_W)) u_ff (
            .x (chain_q [255-32*i -: 32]),
            .y (work_vec[255-32*i -: 32]),
            .s (ff_sum  [255-32*i -: 32])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rnd      <= '0;
            work_q   <= '0;
            chain_q  <= '0;
            digest_q <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        chain_q <= load_val;
                        work_q  <= load_val;
                        rnd     <= '0;
                        st      <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    work_q <= work_nx;
                    rnd    <= rnd + 1'b1;
                    if (rnd == RW'(ROUNDS - 1)) st <= ST_FIN;
                end
                ST_FIN: begin
                    digest_q <= ff_sum;
                    st       <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign word_req = (st == ST_RUN);
    assign done     = (st == ST_DONE);
    assign digest   = digest_q;
endmodule

// File: rtl/sha_apx_chk.sv
module sha_apx_chk #(
    parameter int ROUNDS = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         word_req,
    input logic         done,
    input logic [255:0] digest
);
    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)           run_len <= '0;
        else if (word_req) run_len <= run_len + 1'b1;
        else               run_len <= '0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!done && !word_req && digest == '0));

    a_r2_run_bound: assert property (@(posedge clk) disable iff (rst)
        word_req |-> (run_len < 8'(ROUNDS)));

    a_r2_full_run: assert property (@(posedge clk) disable iff (rst)
        $fell(word_req) |-> (run_len == 8'(ROUNDS)));

    a_r3_done_after_ff: assert property (@(posedge clk) disable iff (rst)
        $fell(word_req) |=> done);

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
        done |-> !word_req);

    a_r7_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
        (word_req && start && run_len < 8'(ROUNDS - 1)) |=> word_req);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(digest)));

    a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (!done && word_req));
endmodule

bind sha_apx_core sha_apx_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .word_req (word_req),
    .done     (done),
    .digest   (digest)
);

// File: tb/tb_sha_apx_core.sv
`timescale 1ns/1ps
module tb_sha_apx_core;
    import sha_apx_pkg::round_const;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         use_iv = 1'b1;
    logic [255:0] chain_in = '0;
    logic [31:0]  word_in;
    logic         req4, req1, req32, done4, done1, done32;
    logic [255:0] dig4, dig1, dig32;

    int checks = 0;
    int errors = 0;

    logic [31:0] wsched [64];
    logic [6:0]  widx = '0;

    always #2 clk = ~clk;

    sha_apx_core #(.SEG_W(4)) dut (
        .clk(clk), .rst(rst), .start(start), .use_iv(use_iv), .chain_in(chain_in),
        .word_in(word_in), .word_req(req4), .done(done4), .digest(dig4));
    sha_apx_core #(.SEG_W(1)) dut_k1 (
        .clk(clk), .rst(rst), .start(start), .use_iv(use_iv), .chain_in(chain_in),
        .word_in(word_in), .word_req(req1), .done(done1), .digest(dig1));
    sha_apx_core #(.SEG_W(32)) dut_exact (
        .clk(clk), .rst(rst), .start(start), .use_iv(use_iv), .chain_in(chain_in),
        .word_in(word_in), .word_req(req32), .done(done32), .digest(dig32));

    assign word_in = wsched[widx[5:0]];

    always @(posedge clk) begin
        if (start && !req4) widx <= '0;
        else if (req4)      widx <= widx + 7'd1;
    end

    // ---------------- reference helpers ----------------
    function automatic logic [31:0] ror(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] sadd(input logic [31:0] x, input logic [31:0] y, input int k);
        logic [31:0] r = '0;
        logic [63:0] m = (64'd1 << k) - 64'd1;
        for (int s = 0; s < 32; s += k) begin
            logic [63:0] part = ((64'(x) >> s) & m) + ((64'(y) >> s) & m);
            r = r | 32'((part & m) << s);
        end
        return r;
    endfunction

    function automatic logic [255:0] model(input logic [255:0] ch, input int k);
        logic [31:0] v [8];
        logic [31:0] c [8];
        logic [31:0] t1, t2, s1, s0, chv, mj;
        logic [255:0] out;
        for (int i = 0; i < 8; i++) begin
            c[i] = ch[255-32*i -: 32];
            v[i] = c[i];
        end
        for (int t = 0; t < 64; t++) begin
            s1  = ror(v[4], 6) ^ ror(v[4], 11) ^ ror(v[4], 25);
            chv = (v[4] & v[5]) ^ (~v[4] & v[6]);
            s0  = ror(v[0], 2) ^ ror(v[0], 13) ^ ror(v[0], 22);
            mj  = (v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]);
            t1  = sadd(sadd(sadd(sadd(v[7], s1, k), chv, k), round_const(6'(t)), k), wsched[t], k);
            t2  = sadd(s0, mj, k);
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4];
            v[4] = sadd(v[3], t1, k);
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0];
            v[0] = sadd(t1, t2, k);
        end
        for (int i = 0; i < 8; i++) out[255-32*i -: 32] = sadd(c[i], v[i], k);
        return out;
    endfunction

    task automatic fill_sched(input logic [511:0] blk);
        for (int t = 0; t < 64; t++) begin
            if (t < 16) wsched[t] = blk[511-32*t -: 32];
            else wsched[t] = (ror(wsched[t-2], 17) ^ ror(wsched[t-2], 19) ^ (wsched[t-2] >> 10))
                           + wsched[t-7]
                           + (ror(wsched[t-15], 7) ^ ror(wsched[t-15], 18) ^ (wsched[t-15] >> 3))
                           + wsched[t-16];
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one block; checks request count (R2), latency (R3) and all digests.
    task automatic run_block(input bit iv, input logic [255:0] ch, input int busy_at,
                             input string tag, output logic [255:0] exact_out);
        logic [255:0] base;
        logic [255:0] exp4, exp1, exp32;
        int cycles, reqs;
        base  = iv ? sha_apx_pkg::INIT_CHAIN : ch;
        exp4  = model(base, 4);
        exp1  = model(base, 1);
        exp32 = model(base, 32);
        @(negedge clk);
        use_iv = iv; chain_in = ch; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        reqs = req4 ? 1 : 0;
        while (!done4 && cycles < 200) begin
            @(negedge clk);
            cycles++;
            start = (cycles == busy_at);
            if (req4) reqs++;
        end
        start = 1'b0;
        check(reqs == 64, {"R2 request cycles ", tag}, 256'(reqs), 256'd64);
        check(cycles == 66, {"R3 done latency ", tag}, 256'(cycles), 256'd66);
        check(done1 && done32, {"R3 all instances done ", tag}, {done1, done32}, 2'b11);
        check(dig4 == exp4, {"R5 sliced-4 digest ", tag}, dig4, exp4);
        check(dig1 == exp1, {"R8 xor digest ", tag}, dig1, exp1);
        check(dig32 == exp32, {"R6 exact digest ", tag}, dig32, exp32);
        exact_out = dig32;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!done4 && !req4, "R1 flags in reset", {done4, req4}, 2'b00);
        rst = 1'b0;
        @(negedge clk);
        check(!done4 && !req4 && !done1 && !req32, "R1 flags after reset",
              {done4, req4, done1, req32}, 4'b0);
        check(dig4 == '0 && dig32 == '0, "R1 digest zero", dig4, '0);
    endtask

    task automatic t_abc();
        logic [511:0] blk = '0;
        logic [255:0] got;
        blk[511 -: 32] = 32'h61626380;
        blk[31:0]      = 32'h00000018;
        fill_sched(blk);
        run_block(1'b1, '1, 0, "abc", got);
        check(got == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
              "R4 abc exact digest", got,
              256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
    endtask

    task automatic t_chain();
        logic [511:0] blk;
        logic [255:0] got;
        for (int t = 0; t < 16; t++) blk[511-32*t -: 32] = 32'h9e3779b9 * (t + 1);
        fill_sched(blk);
        run_block(1'b0, 256'hf0e1d2c3b4a5968778695a4b3c2d1e0fffeeddccbbaa99887766554433221100,
                  0, "R6 chained", got);
        check(got != 256'h0, "R6 chain_in path non-zero", got, '1);
    endtask

    task automatic t_busy();
        logic [255:0] got;
        run_block(1'b1, '0, 20, "R7 busy start mid-run", got);
        run_block(1'b1, '0, 65, "R7 busy start in feed-forward", got);
    endtask

    task automatic t_hold();
        logic [255:0] snap;
        snap = dig4;
        repeat (10) @(negedge clk);
        check(done4 && dig4 == snap, "R9 digest held", dig4, snap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done4 && req4, "R9 restart clears done", {done4, req4}, 2'b01);
        repeat (70) @(negedge clk);
        check(done4, "R9 restarted block finishes", {255'd0, done4}, 256'd1);
    endtask

    initial begin
        t_reset();
        t_abc();
        t_chain();
        t_busy();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule